// File: doc/BRIEF.md
# Dual-Compare 8-Bit Timer Channel

This block is one channel of a byte-wide timer. A CPU reaches its five registers through a small register port: a control byte, a status byte, two compare constants and the counter itself. The counter advances by one on each count pulse. The pulse comes from a free-running prescaler (one of three internal divide ratios) or from an external clock input. The external input passes through a two-stage synchronizer and can be counted on its rising edge, its falling edge or both.

On a count pulse, the counter is compared against each constant. A match sets a status flag. If the control byte asks for it, the same pulse clears the counter instead of advancing it. As an alternative, a rising edge on a synchronized external reset input can clear the counter. Advancing past the all-ones value sets an overflow flag. Software can clear the status flags by writing 0 to them, but it can never set them.

Each external input goes through an edge tracker: a two-state machine with states `LVL_LOW` and `LVL_HIGH`. The transition `LVL_LOW -> LVL_HIGH` fires when the synchronized level is 1 and produces a rise event. The transition `LVL_HIGH -> LVL_LOW` fires when the synchronized level is 0 and produces a fall event. In every other case the state holds and no event is produced.

Top module: `tmr8_channel`

## Requirements
- R1: After reset the registers read as follows: control 0x00, status 0x10, constant A 0xFF, constant B 0xFF, counter 0x00.
- R2: Register addresses are fixed by `reg_sel`: 0 control, 1 status, 2 constant A, 3 constant B, 4 counter. All eight control bits are stored and read back. Control bits [2:0] select the count source and bits [4:3] select the clear source. Status bit 7 is the B-match flag, bit 6 the A-match flag and bit 5 the overflow flag; status bits [4:0] always read 10000. Constants and counter are written and read as whole bytes. Reads are combinational.
- R3: Count-source codes 001, 010 and 011 give exactly one count pulse every 8, 64 and 1024 clocks respectively.
- R4: Count-source codes 101, 110 and 111 count the external clock's rising edges, falling edges or both edges, seen through a two-flop synchronizer. Codes 000 and 100 hold the counter still.
- R5: A match event with A happens on a count pulse that finds the counter equal to constant A; it sets the A flag. With clear source 01, that pulse loads 0x00 instead of incrementing.
- R6: The same holds for constant B, the B flag and clear source 10.
- R7: A count pulse that advances the counter from 0xFF to 0x00 sets the overflow flag. A clear by match at 0xFF does not set it.
- R8: With clear source 11, a rising edge of the synchronized external reset input clears the counter. With any other clear source, that input has no effect.
- R9: Writing 0 to a status flag bit clears that flag. Writing 1 leaves it unchanged, so software cannot set a flag.
- R10: A CPU write to the counter takes priority over an increment or clear in the same cycle.
- R11: If a hardware flag set and a software clear of that flag fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 3 | Register address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register |
| ext_clk_in | input | 1 | External count clock, asynchronous |
| ext_rst_in | input | 1 | External counter clear, asynchronous |

## Verification
The hardest case to reach is a count pulse that lands in the same clock as a CPU write: a counter write (R10) or a status clear that races a fresh match (R11). With internal prescaled pulses the phase is hidden, so the bench uses the external clock instead. From the cycle the input is driven high, it counts the two synchronizer stages and the edge tracker, which places the count pulse on the third rising clock edge, and it issues the write so that it lands on exactly that edge. A control run with no write confirms the pulse falls on that edge. The prescaler ratios are checked with windows that are whole multiples of each ratio, so the result does not depend on the prescaler phase.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;

    typedef enum logic [2:0] {
        CKS_STOP     = 3'b000,
        CKS_DIV_FAST = 3'b001,
        CKS_DIV_MID  = 3'b010,
        CKS_DIV_SLOW = 3'b011,
        CKS_UNUSED   = 3'b100,
        CKS_EXT_RISE = 3'b101,
        CKS_EXT_FALL = 3'b110,
        CKS_EXT_BOTH = 3'b111
    } clk_sel_e;

    typedef enum logic [1:0] {
        CLR_NONE    = 2'b00,
        CLR_MATCH_A = 2'b01,
        CLR_MATCH_B = 2'b10,
        CLR_EXT_RST = 2'b11
    } clr_sel_e;

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_e;

    localparam int SEL_W = 3;
    localparam logic [SEL_W-1:0] ADDR_CTRL  = 3'd0;
    localparam logic [SEL_W-1:0] ADDR_STAT  = 3'd1;
    localparam logic [SEL_W-1:0] ADDR_CONSA = 3'd2;
    localparam logic [SEL_W-1:0] ADDR_CONSB = 3'd3;
    localparam logic [SEL_W-1:0] ADDR_CNT   = 3'd4;

    localparam int FLAG_B_BIT   = 7;
    localparam int FLAG_A_BIT   = 6;
    localparam int FLAG_OVF_BIT = 5;

endpackage

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
    parameter int FAST_LOG = 3,
    parameter int MID_LOG  = 6,
    parameter int SLOW_LOG = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_fast,
    output logic tick_mid,
    output logic tick_slow
);
    localparam int PW = SLOW_LOG;

    logic [PW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_q + 1'b1;
    end

    always_comb begin
        tick_fast = &div_q[FAST_LOG-1:0];
        tick_mid  = &div_q[MID_LOG-1:0];
        tick_slow = &div_q[SLOW_LOG-1:0];
    end

    // R3: the fastest tick never fires on two consecutive clocks
    assert_fast_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_fast |=> !tick_fast);

    // R3: slower ticks line up with faster ones
    assert_ticks_nested_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_slow |-> (tick_mid && tick_fast));

endmodule

// File: rtl/tmr8_edge_det.sv
module tmr8_edge_det
    import tmr8_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    input  logic want_rise,
    input  logic want_fall,
    output logic pulse_o
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    lvl_state_e             state_q, state_d;
    logic                   rise, fall;

    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], async_in};
    end

    assign level = sync_q[SYNC_STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_LOW;
        else        state_q <= state_d;
    end

    // next state and outputs
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (level) begin
                    state_d = LVL_HIGH;
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!level) begin
                    state_d = LVL_LOW;
                    fall    = 1'b1;
                end
            end
        endcase
        pulse_o = (rise && want_rise) || (fall && want_fall);
    end

    // R4: an event only appears when the synchronized level has just changed
    assert_pulse_on_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> (state_q != $past(state_q)));

    // R4: rise and fall are never reported together
    assert_one_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise && fall));

endmodule

// File: rtl/tmr8_channel.sv
module tmr8_channel
    import tmr8_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int FAST_LOG    = 3,
    parameter int MID_LOG     = 6,
    parameter int SLOW_LOG    = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        reg_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ext_clk_in,
    input  logic              ext_rst_in
);
    localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] STAT_FILL = DATA_W'(16);

    logic [DATA_W-1:0] ctrl_q, cons_a_q, cons_b_q, cnt_q;
    logic              flag_a_q, flag_b_q, flag_ovf_q;

    clk_sel_e cks;
    clr_sel_e clrs;
    logic tick_fast, tick_mid, tick_slow;
    logic ext_pulse, xrst_rise;
    logic want_rise, want_fall;
    logic cnt_pulse;
    logic wr_ctrl, wr_stat, wr_cons_a, wr_cons_b, wr_cnt;
    logic match_a_evt, match_b_evt, clr_by_match, ext_clr, ovf_evt;

    assign cks  = clk_sel_e'(ctrl_q[2:0]);
    assign clrs = clr_sel_e'(ctrl_q[4:3]);

    assign wr_ctrl   = wr_en && (reg_sel == ADDR_CTRL);
    assign wr_stat   = wr_en && (reg_sel == ADDR_STAT);
    assign wr_cons_a = wr_en && (reg_sel == ADDR_CONSA);
    assign wr_cons_b = wr_en && (reg_sel == ADDR_CONSB);
    assign wr_cnt    = wr_en && (reg_sel == ADDR_CNT);

    tmr8_prescaler #(
        .FAST_LOG (FAST_LOG),
        .MID_LOG  (MID_LOG),
        .SLOW_LOG (SLOW_LOG)
    ) u_presc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_fast (tick_fast),
        .tick_mid  (tick_mid),
        .tick_slow (tick_slow)
    );

    assign want_rise = (cks == CKS_EXT_RISE) || (cks == CKS_EXT_BOTH);
    assign want_fall = (cks == CKS_EXT_FALL) || (cks == CKS_EXT_BOTH);

    tmr8_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_xclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (ext_clk_in),
        .want_rise (want_rise),
        .want_fall (want_fall),
        .pulse_o   (ext_pulse)
    );

    tmr8_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_xrst (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (ext_rst_in),
        .want_rise (1'b1),
        .want_fall (1'b0),
        .pulse_o   (xrst_rise)
    );

    always_comb begin
        case (cks)
            CKS_DIV_FAST: cnt_pulse = tick_fast;
            CKS_DIV_MID:  cnt_pulse = tick_mid;
            CKS_DIV_SLOW: cnt_pulse = tick_slow;
            CKS_EXT_RISE,
            CKS_EXT_FALL,
            CKS_EXT_BOTH: cnt_pulse = ext_pulse;
            default:      cnt_pulse = 1'b0;
        endcase
    end

    assign match_a_evt  = cnt_pulse && (cnt_q == cons_a_q);
    assign match_b_evt  = cnt_pulse && (cnt_q == cons_b_q);
    assign clr_by_match = ((clrs == CLR_MATCH_A) && match_a_evt) ||
                          ((clrs == CLR_MATCH_B) && match_b_evt);
    assign ext_clr      = (clrs == CLR_EXT_RST) && xrst_rise;
    assign ovf_evt      = cnt_pulse && (cnt_q == ALL_ONES) && !clr_by_match &&
                          !ext_clr && !wr_cnt;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            cons_a_q <= ALL_ONES;
            cons_b_q <= ALL_ONES;
        end else begin
            if (wr_ctrl)   ctrl_q   <= wr_data;
            if (wr_cons_a) cons_a_q <= wr_data;
            if (wr_cons_b) cons_b_q <= wr_data;
        end
    end

    // counter: CPU write, then external clear, then count pulse
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt_q <= '0;
        else if (wr_cnt)     cnt_q <= wr_data;
        else if (ext_clr)    cnt_q <= '0;
        else if (cnt_pulse)  cnt_q <= clr_by_match ? '0 : cnt_q + 1'b1;
    end

    // flags: hardware set wins over software clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_a_q   <= 1'b0;
            flag_b_q   <= 1'b0;
            flag_ovf_q <= 1'b0;
        end else begin
            flag_a_q   <= match_a_evt | (flag_a_q   & ~(wr_stat & ~wr_data[FLAG_A_BIT]));
            flag_b_q   <= match_b_evt | (flag_b_q   & ~(wr_stat & ~wr_data[FLAG_B_BIT]));
            flag_ovf_q <= ovf_evt     | (flag_ovf_q & ~(wr_stat & ~wr_data[FLAG_OVF_BIT]));
        end
    end

    always_comb begin
        case (reg_sel)
            ADDR_CTRL:  rd_data = ctrl_q;
            ADDR_STAT:  rd_data = STAT_FILL | ({{(DATA_W-3){1'b0}}, flag_b_q, flag_a_q, flag_ovf_q}
                                                << FLAG_OVF_BIT);
            ADDR_CONSA: rd_data = cons_a_q;
            ADDR_CONSB: rd_data = cons_b_q;
            ADDR_CNT:   rd_data = cnt_q;
            default:    rd_data = '0;
        endcase
    end

    assert_cpu_wr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wr_data)));

    assert_ovf_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> (flag_ovf_q && cnt_q == '0));

    // R5 and R6 share this check
    assert_match_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_by_match && !wr_cnt && !ext_clr) |=> (cnt_q == '0));

    assert_ext_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clr && !wr_cnt) |=> (cnt_q == '0));

    assert_no_sw_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_a_q && !match_a_evt) |=> !flag_a_q);

    assert_hw_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        match_b_evt |=> flag_b_q);

    assert_hold_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_pulse && !wr_cnt && !ext_clr) |=> $stable(cnt_q));

endmodule

// File: tb/tmr8_channel_tb_top.sv
module tmr8_channel_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       ext_clk_in = 1'b0;
    logic       ext_rst_in = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    tmr8_channel dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_sel    (reg_sel),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .ext_clk_in (ext_clk_in),
        .ext_rst_in (ext_rst_in)
    );

    localparam logic [2:0] A_CTRL = 3'd0, A_STAT = 3'd1, A_CA = 3'd2, A_CB = 3'd3, A_CNT = 3'd4;

    // all tasks start and end just after a falling clock edge
    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        reg_sel = sel; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] sel, input logic [7:0] exp, input string tag);
        reg_sel = sel;
        #1;
        n_checks++;
        if (rd_data !== exp) begin
            n_fails++;
            $display("FAIL %s: sel %0d got %h expected %h", tag, sel, rd_data, exp);
        end
    endtask

    task automatic xclk_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1'b1;
            repeat (4) @(negedge clk);
            ext_clk_in = 1'b0;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic t_reset_values();
        rd_chk(A_CTRL, 8'h00, "R1 ctrl");
        rd_chk(A_STAT, 8'h10, "R1 stat");
        rd_chk(A_CA,   8'hFF, "R1 consA");
        rd_chk(A_CB,   8'hFF, "R1 consB");
        rd_chk(A_CNT,  8'h00, "R1 cnt");
    endtask

    task automatic t_reg_access();
        wr(A_CA, 8'h5A);  rd_chk(A_CA, 8'h5A, "R2 consA");
        wr(A_CB, 8'hA5);  rd_chk(A_CB, 8'hA5, "R2 consB");
        wr(A_CNT, 8'h3C); rd_chk(A_CNT, 8'h3C, "R2 cnt");
        wr(A_CTRL, 8'hE0); rd_chk(A_CTRL, 8'hE0, "R2 ctrl");
        rd_chk(A_CNT, 8'h3C, "R2 cnt held while stopped");
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_prescale();
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h01); repeat (79) @(negedge clk); wr(A_CTRL, 8'h00);
        rd_chk(A_CNT, 8'd10, "R3 div8 80 clocks");
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h02); repeat (127) @(negedge clk); wr(A_CTRL, 8'h00);
        rd_chk(A_CNT, 8'd2, "R3 div64 128 clocks");
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h03); repeat (1023) @(negedge clk); wr(A_CTRL, 8'h00);
        rd_chk(A_CNT, 8'd1, "R3 div1024 1024 clocks");
    endtask

    task automatic t_external();
        wr(A_CA, 8'h80); wr(A_CB, 8'h81);
        wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h05); xclk_pulses(3); rd_chk(A_CNT, 8'd3, "R4 rising");
        wr(A_CTRL, 8'h06); xclk_pulses(3); rd_chk(A_CNT, 8'd6, "R4 falling");
        wr(A_CTRL, 8'h07); xclk_pulses(3); rd_chk(A_CNT, 8'd12, "R4 both edges");
        wr(A_CTRL, 8'h00); xclk_pulses(2); rd_chk(A_CNT, 8'd12, "R4 stop code 000");
        wr(A_CTRL, 8'h04); xclk_pulses(2); rd_chk(A_CNT, 8'd12, "R4 unused code 100");
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_clear_a();
        wr(A_STAT, 8'h00);
        wr(A_CA, 8'h03); wr(A_CB, 8'h80); wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h0D);
        xclk_pulses(3);
        rd_chk(A_CNT, 8'h03, "R5 reaches constant A");
        rd_chk(A_STAT, 8'h10, "R5 no flag before match pulse");
        xclk_pulses(1);
        rd_chk(A_CNT, 8'h00, "R5 cleared by match A");
        rd_chk(A_STAT, 8'h50, "R5 flag A set");
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_clear_b();
        wr(A_STAT, 8'h00);
        wr(A_CB, 8'h02); wr(A_CA, 8'h80); wr(A_CNT, 8'h00);
        wr(A_CTRL, 8'h15);
        xclk_pulses(3);
        rd_chk(A_CNT, 8'h00, "R6 cleared by match B");
        rd_chk(A_STAT, 8'h90, "R6 flag B set");
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_overflow();
        wr(A_STAT, 8'h00);
        wr(A_CA, 8'h80); wr(A_CB, 8'h81); wr(A_CNT, 8'hFE);
        wr(A_CTRL, 8'h05);
        xclk_pulses(2);
        rd_chk(A_CNT, 8'h00, "R7 wrap to zero");
        rd_chk(A_STAT, 8'h30, "R7 overflow flag");
        wr(A_STAT, 8'h00);
        wr(A_CA, 8'hFF); wr(A_CNT, 8'hFE);
        wr(A_CTRL, 8'h0D);
        xclk_pulses(2);
        rd_chk(A_CNT, 8'h00, "R7 match clear at FF");
        rd_chk(A_STAT, 8'h50, "R7 no overflow on match clear");
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_ext_reset();
        wr(A_CNT, 8'h40);
        wr(A_CTRL, 8'h00);
        ext_rst_in = 1'b1; repeat (5) @(negedge clk);
        rd_chk(A_CNT, 8'h40, "R8 ignored when clear source 00");
        ext_rst_in = 1'b0; repeat (5) @(negedge clk);
        wr(A_CTRL, 8'h18);
        rd_chk(A_CNT, 8'h40, "R8 no clear before edge");
        ext_rst_in = 1'b1; repeat (5) @(negedge clk);
        rd_chk(A_CNT, 8'h00, "R8 cleared by external edge");
        ext_rst_in = 1'b0; repeat (5) @(negedge clk);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_flag_write();
        wr(A_STAT, 8'h00);
        wr(A_STAT, 8'hFF);
        rd_chk(A_STAT, 8'h10, "R9 writing ones sets nothing");
        wr(A_CA, 8'h01); wr(A_CB, 8'h01); wr(A_CNT, 8'h01);
        wr(A_CTRL, 8'h05);
        xclk_pulses(1);
        wr(A_CTRL, 8'h00);
        rd_chk(A_STAT, 8'hD0, "R9 both match flags set");
        wr(A_STAT, 8'hBF);
        rd_chk(A_STAT, 8'h90, "R9 clear only flag A");
        wr(A_STAT, 8'h7F);
        rd_chk(A_STAT, 8'h10, "R9 clear flag B");
    endtask

    task automatic t_write_priority();
        wr(A_CA, 8'h80); wr(A_CB, 8'h81);
        wr(A_CTRL, 8'h05);
        wr(A_CNT, 8'h30);
        ext_clk_in = 1'b1;
        @(negedge clk); @(negedge clk);
        @(negedge clk);
        rd_chk(A_CNT, 8'h31, "R10 pulse lands on third edge");
        ext_clk_in = 1'b0; repeat (4) @(negedge clk);
        wr(A_CNT, 8'h30);
        ext_clk_in = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(A_CNT, 8'h77);
        rd_chk(A_CNT, 8'h77, "R10 CPU write beats increment");
        ext_clk_in = 1'b0; repeat (4) @(negedge clk);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic t_set_beats_clear();
        wr(A_STAT, 8'h00);
        wr(A_CA, 8'h50); wr(A_CB, 8'h81); wr(A_CNT, 8'h50);
        wr(A_CTRL, 8'h05);
        ext_clk_in = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(A_STAT, 8'h00);
        rd_chk(A_STAT, 8'h50, "R11 flag set despite same-cycle clear");
        rd_chk(A_CNT, 8'h51, "R11 count advanced");
        ext_clk_in = 1'b0; repeat (4) @(negedge clk);
        wr(A_STAT, 8'h00);
        rd_chk(A_STAT, 8'h10, "R11 later clear works");
        wr(A_CTRL, 8'h00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values();
        t_reg_access();
        t_prescale();
        t_external();
        t_clear_a();
        t_clear_b();
        t_overflow();
        t_ext_reset();
        t_flag_write();
        t_write_priority();
        t_set_beats_clear();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule